// File: doc/BRIEF.md
# Pulse Interrupt Hub

The block gathers up to 32 interrupt sources behind an APB3 slave port with a 16-bit address and 32-bit data, and drives a single interrupt line. In its default pulse mode, each source is a one-cycle event. The event sets a sticky pending bit that software clears by writing 1 to it. A per-bit force register lets software raise any source on purpose, for example to debug a handler. A per-bit mask, in which 1 blocks the bit, decides which pending or forced bits reach the output.

A parameter selects a level-merge variant. In that variant the inputs are already level interrupts, such as the lines of other hubs. Each input passes through the mask alone, with no pending or force stage, so the output follows the inputs directly.

The registers occupy consecutive 32-bit words from a base address. Every access completes in one access cycle, and no access reports an error.

Top module: `pulseIrqHub`

## Requirements
- R1: After reset, in pulse mode, the pending register reads 0, the force register reads 0, the block register reads all ones in bits [NUM_IRQ-1:0], the visible register reads 0, and irqOut is low.
- R2: A high cycle on irqEvent[i] in pulse mode sets pending bit i at the next clock edge. The bit then stays set until software clears it.
- R3: The pending register sits at offset 0x0. Writing a 1 to bit i clears pending bit i, and writing a 0 to a bit leaves it unchanged.
- R4: When an event on bit i and a write of 1 to pending bit i fall in the same cycle, the event wins and the bit remains set.
- R5: The force register at offset 0x4 is read/write over bits [NUM_IRQ-1:0]. Write data above NUM_IRQ is dropped, and those bits read as 0 in every register.
- R6: The block register sits at offset 0x8, and a 1 in bit i keeps source i away from the output. Because it resets to all ones, every source starts blocked.
- R7: The visible register at offset 0xC reads (pending OR force) AND NOT block, bit by bit. irqOut is high exactly when any visible bit is 1, and it changes in the same cycle as the registers it depends on.
- R8: Writes to the visible register change nothing.
- R9: Reads of any offset that is not mapped, including misaligned offsets, return 0. Writes to such offsets change nothing. pready is always high and pslverr is always low.
- R10: With LEVEL_MODE=1, the block register sits at offset 0x0 and resets to all ones. The visible register sits at offset 0x4 and reads irqEvent AND NOT block, with no memory of past inputs. Every other offset is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high, read when low |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Always low |
| irqEvent | input | NUM_IRQ | Event pulses in pulse mode, level inputs in level mode |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench targets a clearing write that lands in the same cycle as a new event on the same bit. A design that let the write win would silently lose that interrupt.

It also writes 0 bits alongside 1 bits to the pending register. A design that treated the write as a plain store would wipe other pending sources.

Three further cases are each confirmed by reading the other registers back afterwards: writes to the read-only visible word, writes to unmapped words, and write data above the source count. A design that decoded addresses loosely, or stored the wide data, would corrupt state.

In level mode, the bench drops an input after it has been seen. A design that latched level inputs would keep irqOut high.

// File: rtl/irqHubPkg.sv
package irqHubPkg;

  // Which register a read access selects.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_FORCE,
    SEL_BLOCK,
    SEL_VISIBLE
  } regSel_e;

  // Strobes the bus control hands to the register datapath.
  typedef struct packed {
    logic    wrPend;
    logic    wrForce;
    logic    wrBlock;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/irqBusCtrl.sv
module irqBusCtrl
  import irqHubPkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter bit              LEVEL_MODE = 1'b0
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output busStrobe_t        strobe,
  output logic              pready,
  output logic              pslverr
);

  localparam int              REG_COUNT = LEVEL_MODE ? 2 : 4;
  localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(REG_COUNT * 4);

  logic [ADDR_W-1:0] offset;
  logic              inRange;
  logic [1:0]        wordIdx;
  regSel_e           hitSel;
  logic              wrAccess;

  always_comb begin
    offset   = paddr - BASE_ADDR;
    inRange  = (offset < SPAN) && (offset[1:0] == 2'b00);
    wordIdx  = offset[3:2];
    wrAccess = psel && penable && pwrite && inRange;
  end

  generate
    if (LEVEL_MODE) begin : gLevelMap
      always_comb begin
        unique case (wordIdx)
          2'd0:    hitSel = SEL_BLOCK;
          2'd1:    hitSel = SEL_VISIBLE;
          default: hitSel = SEL_NONE;
        endcase
      end
    end else begin : gPulseMap
      always_comb begin
        unique case (wordIdx)
          2'd0:    hitSel = SEL_PEND;
          2'd1:    hitSel = SEL_FORCE;
          2'd2:    hitSel = SEL_BLOCK;
          default: hitSel = SEL_VISIBLE;
        endcase
      end
    end
  endgenerate

  always_comb begin
    strobe.wrPend  = wrAccess && (hitSel == SEL_PEND);
    strobe.wrForce = wrAccess && (hitSel == SEL_FORCE);
    strobe.wrBlock = wrAccess && (hitSel == SEL_BLOCK);
    strobe.rdSel   = (psel && !pwrite && inRange) ? hitSel : SEL_NONE;
    pready         = 1'b1;
    pslverr        = 1'b0;
  end

endmodule

// File: rtl/irqRegBank.sv
module irqRegBank
  import irqHubPkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int DATA_W     = 32,
  parameter bit LEVEL_MODE = 1'b0
) (
  input  logic               pclk,
  input  logic               presetn,
  input  busStrobe_t         strobe,
  input  logic [DATA_W-1:0]  pwdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic [DATA_W-1:0]  prdata,
  output logic [NUM_IRQ-1:0] pendQ,
  output logic [NUM_IRQ-1:0] forceQ,
  output logic [NUM_IRQ-1:0] blockQ,
  output logic               irqOut
);

  logic [NUM_IRQ-1:0] wrBits;
  logic [NUM_IRQ-1:0] srcVec;
  logic [NUM_IRQ-1:0] visibleVec;
  logic               unusedSink;

  assign wrBits = pwdata[NUM_IRQ-1:0];

  generate
    if (LEVEL_MODE) begin : gLevel
      // Level inputs go straight to the mask; no pending or force stage.
      assign pendQ      = '0;
      assign forceQ     = '0;
      assign srcVec     = irqIn;
      assign unusedSink = ^{pwdata, strobe.wrPend, strobe.wrForce};
    end else begin : gPulse
      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          pendQ <= '0;
        end else begin
          // A new event overrides a clear of the same bit.
          pendQ <= (pendQ & ~(strobe.wrPend ? wrBits : '0)) | irqIn;
        end
      end

      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          forceQ <= '0;
        end else if (strobe.wrForce) begin
          forceQ <= wrBits;
        end
      end

      assign srcVec     = pendQ | forceQ;
      assign unusedSink = ^pwdata;
    end
  endgenerate

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      blockQ <= '1;
    end else if (strobe.wrBlock) begin
      blockQ <= wrBits;
    end
  end

  always_comb begin
    visibleVec = srcVec & ~blockQ;
    irqOut     = |visibleVec;
  end

  always_comb begin
    prdata = '0;
    unique case (strobe.rdSel)
      SEL_PEND:    prdata[NUM_IRQ-1:0] = pendQ;
      SEL_FORCE:   prdata[NUM_IRQ-1:0] = forceQ;
      SEL_BLOCK:   prdata[NUM_IRQ-1:0] = blockQ;
      SEL_VISIBLE: prdata[NUM_IRQ-1:0] = visibleVec;
      default:     prdata = '0;
    endcase
  end

endmodule

// File: rtl/pulseIrqHub.sv
module pulseIrqHub
  import irqHubPkg::*;
#(
  parameter int                NUM_IRQ    = 8,
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter bit                LEVEL_MODE = 1'b0
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_IRQ-1:0] irqEvent,
  output logic               irqOut
);

  busStrobe_t         strobe;
  logic [NUM_IRQ-1:0] pendQ;
  logic [NUM_IRQ-1:0] forceQ;
  logic [NUM_IRQ-1:0] blockQ;

  irqBusCtrl #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .LEVEL_MODE(LEVEL_MODE)
  ) uCtrl (
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .strobe (strobe),
    .pready (pready),
    .pslverr(pslverr)
  );

  irqRegBank #(
    .NUM_IRQ   (NUM_IRQ),
    .DATA_W    (DATA_W),
    .LEVEL_MODE(LEVEL_MODE)
  ) uBank (
    .pclk   (pclk),
    .presetn(presetn),
    .strobe (strobe),
    .pwdata (pwdata),
    .irqIn  (irqEvent),
    .prdata (prdata),
    .pendQ  (pendQ),
    .forceQ (forceQ),
    .blockQ (blockQ),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/irqHubChk.sv
module irqHubChk #(
  parameter int                NUM_IRQ    = 8,
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter bit                LEVEL_MODE = 1'b0
) (
  input logic               pclk,
  input logic               presetn,
  input logic               psel,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [DATA_W-1:0]  prdata,
  input logic               pready,
  input logic               pslverr,
  input logic [NUM_IRQ-1:0] irqEvent,
  input logic               irqOut,
  input logic [NUM_IRQ-1:0] pendQ,
  input logic [NUM_IRQ-1:0] forceQ,
  input logic [NUM_IRQ-1:0] blockQ,
  input logic               wrPend
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'((LEVEL_MODE ? 2 : 4) * 4);

  logic [ADDR_W-1:0] offsetC;
  logic              outside;
  assign offsetC = paddr - BASE_ADDR;
  assign outside = (offsetC >= SPAN);

  generate
    if (!LEVEL_MODE) begin : gPulseChk
      // R2
      event_sets_pend_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (irqEvent != '0) |=> ((pendQ & $past(irqEvent)) == $past(irqEvent)));
      // R3
      pend_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (!wrPend && irqEvent == '0) |=> (pendQ == $past(pendQ)));
      // R5
      force_fires_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ((forceQ & ~blockQ) != '0) |-> irqOut);
    end else begin : gLevelChk
      logic unusedLvl;
      assign unusedLvl = ^{pendQ, forceQ, wrPend};
      // R10
      level_follow_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ((irqEvent & ~blockQ) != '0) |-> irqOut);
      // R10
      level_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ((irqEvent & ~blockQ) == '0) |-> !irqOut);
    end
  endgenerate

  // R6
  all_blocked_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (blockQ == '1) |-> !irqOut);

  // R9
  unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && outside) |-> (prdata == '0 && pready && !pslverr));

endmodule

bind pulseIrqHub irqHubChk #(
  .NUM_IRQ   (NUM_IRQ),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_ADDR (BASE_ADDR),
  .LEVEL_MODE(LEVEL_MODE)
) chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .pready  (pready),
  .pslverr (pslverr),
  .irqEvent(irqEvent),
  .irqOut  (irqOut),
  .pendQ   (pendQ),
  .forceQ  (forceQ),
  .blockQ  (blockQ),
  .wrPend  (strobe.wrPend)
);

// File: tb/pulseIrqHub_test.sv
module pulseIrqHub_test;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        pselA = 1'b0;
  logic        pselB = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdataA, prdataB;
  logic        preadyA, preadyB, pslverrA, pslverrB;
  logic [7:0]  evtA = '0;
  logic [7:0]  lvlB = '0;
  logic        irqA, irqB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          tgt;
    string       tag;
  } rdItem_t;
  rdItem_t rdQ[$];

  always #5 pclk = ~pclk;

  pulseIrqHub #(.NUM_IRQ(8)) uut (
    .pclk(pclk), .presetn(presetn), .psel(pselA), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdataA),
    .pready(preadyA), .pslverr(pslverrA), .irqEvent(evtA), .irqOut(irqA)
  );

  pulseIrqHub #(.NUM_IRQ(8), .LEVEL_MODE(1'b1)) uutLvl (
    .pclk(pclk), .presetn(presetn), .psel(pselB), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdataB),
    .pready(preadyB), .pslverr(pslverrB), .irqEvent(lvlB), .irqOut(irqB)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input bit tgt, input logic [15:0] a, input logic [31:0] d,
                          input logic [7:0] evt = 8'h00);
    @(negedge pclk);
    pselA = !tgt; pselB = tgt; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1; evtA = evt;
    @(negedge pclk);
    pselA = 1'b0; pselB = 1'b0; penable = 1'b0; pwrite = 1'b0; evtA = '0;
  endtask

  task automatic apbRead(input bit tgt, input logic [15:0] a, input logic [31:0] exp,
                         input string tag);
    rdItem_t it;
    it.exp = exp; it.tgt = tgt; it.tag = tag;
    rdQ.push_back(it);
    @(negedge pclk);
    pselA = !tgt; pselB = tgt; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    pselA = 1'b0; pselB = 1'b0; penable = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] v);
    @(negedge pclk); evtA = v;
    @(negedge pclk); evtA = '0;
  endtask

  task automatic checkIrq(input bit tgt, input logic exp, input string tag);
    @(negedge pclk);
    #2;
    checkEq(tag, {31'b0, tgt ? irqB : irqA}, {31'b0, exp});
  endtask

  // Monitor: compares each read-access result against the queued expectation.
  always @(negedge pclk) begin
    #2;
    if ((pselA || pselB) && penable && !pwrite) begin
      if (rdQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: actual unexpected read expected none queued");
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        checkEq(it.tag, it.tgt ? prdataB : prdataA, it.exp);
        checkEq("R9 pready/pslverr", {30'b0, it.tgt ? preadyB : preadyA,
                                      it.tgt ? pslverrB : pslverrA}, 32'h2);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;

    // R1 reset values
    apbRead(0, 16'h0, 32'h0,  "R1 pending reset");
    apbRead(0, 16'h4, 32'h0,  "R1 force reset");
    apbRead(0, 16'h8, 32'hFF, "R1/R6 block reset");
    apbRead(0, 16'hC, 32'h0,  "R1 visible reset");
    checkIrq(0, 1'b0, "R1 irqOut reset");

    // R2 event sets a pending bit; R6 still blocked
    pulseEvt(8'h08);
    apbRead(0, 16'h0, 32'h08, "R2 pending set");
    apbRead(0, 16'hC, 32'h00, "R6 blocked visible");
    checkIrq(0, 1'b0, "R6 irqOut blocked");

    // R7 unblock bit 3
    apbWrite(0, 16'h8, 32'hF7);
    apbRead(0, 16'hC, 32'h08, "R7 visible after unblock");
    checkIrq(0, 1'b1, "R7 irqOut high");
    repeat (4) @(negedge pclk);
    apbRead(0, 16'h0, 32'h08, "R2 pending sticky");

    // R3 write-one clears
    apbWrite(0, 16'h0, 32'h08);
    apbRead(0, 16'h0, 32'h00, "R3 pending cleared");
    checkIrq(0, 1'b0, "R3 irqOut low after clear");

    // R3 zero bits leave others alone
    pulseEvt(8'h22);
    apbWrite(0, 16'h0, 32'h02);
    apbRead(0, 16'h0, 32'h20, "R3 partial clear");

    // R5 force register, upper data dropped; R7 combination
    apbWrite(0, 16'h8, 32'h00);
    apbWrite(0, 16'h4, 32'hFFFFFF80);
    apbRead(0, 16'h4, 32'h80, "R5 force readback");
    apbRead(0, 16'hC, 32'hA0, "R7 visible pend|force");
    apbWrite(0, 16'h4, 32'h0);
    apbWrite(0, 16'h0, 32'h20);
    apbRead(0, 16'hC, 32'h00, "R7 visible empty");
    checkIrq(0, 1'b0, "R7 irqOut low");

    // R4 event wins over a clear in the same cycle
    pulseEvt(8'h04);
    apbWrite(0, 16'h0, 32'h04, 8'h04);
    apbRead(0, 16'h0, 32'h04, "R4 event beats clear");
    apbWrite(0, 16'h0, 32'h04);
    apbRead(0, 16'h0, 32'h00, "R4 later clear works");

    // R8 writes to visible ignored
    apbWrite(0, 16'hC, 32'hFFFFFFFF);
    apbRead(0, 16'h0, 32'h00, "R8 pending untouched");
    apbRead(0, 16'h4, 32'h00, "R8 force untouched");
    apbRead(0, 16'h8, 32'h00, "R8 block untouched");
    checkIrq(0, 1'b0, "R8 irqOut low");

    // R9 unmapped offsets
    apbWrite(0, 16'h10, 32'hFF);
    apbWrite(0, 16'h6, 32'hFF);
    apbRead(0, 16'h10, 32'h0, "R9 unmapped read");
    apbRead(0, 16'h6,  32'h0, "R9 misaligned read");
    apbRead(0, 16'h8,  32'h0, "R9 block unchanged");
    apbRead(0, 16'h4,  32'h0, "R9 force unchanged");

    // R10 level mode
    apbRead(1, 16'h0, 32'hFF, "R10 level block reset");
    @(negedge pclk); lvlB = 8'h05;
    apbRead(1, 16'h4, 32'h00, "R10 level blocked");
    checkIrq(1, 1'b0, "R10 level irq blocked");
    apbWrite(1, 16'h0, 32'hFA);
    apbRead(1, 16'h4, 32'h05, "R10 level visible");
    checkIrq(1, 1'b1, "R10 level irq high");
    @(negedge pclk); lvlB = 8'h01;
    apbRead(1, 16'h4, 32'h01, "R10 level follows");
    @(negedge pclk); lvlB = 8'h00;
    apbRead(1, 16'h4, 32'h00, "R10 level not sticky");
    checkIrq(1, 1'b0, "R10 level irq low");
    apbRead(1, 16'h8, 32'h00, "R10 level unmapped");

    repeat (3) @(negedge pclk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule